// File: doc/BRIEF.md
# Rename Physical Register Free List

This block holds the unallocated physical registers of an out-of-order core's rename stage. Physical registers share one index space. Integer registers take the low indices, and floating-point registers start right after the last integer index. Each class has its own first-in, first-out pool. The rename stage can take one register per cycle from each pool. An allocation that succeeds shows its result in the same cycle as the request.

Retired registers come back in two ways. The unified release port sorts a returned index into a pool by its range. It silently drops the hardwired zero registers and any index outside the physical space. Each pool also has a direct release port, which writes the given index into that pool with no checks at all. Each pool reports whether it is non-empty and how many entries it holds. Each pool also has sticky flags for underflow (an allocation request while the pool is empty) and overflow (a release into a pool that is full, which is usually a double free).

Top module: `regfree_list`

## Requirements
- R1: After reset, the integer pool holds indices NUM_LOG_INT..NUM_PHYS_INT-1 and the FP pool holds NUM_PHYS_INT+NUM_LOG_FP..NUM_PHYS_INT+NUM_PHYS_FP-1. Both are in ascending order, and all four error flags are low.
- R2: A successful allocation shows `*_alloc_valid` high and the oldest entry on `*_alloc_idx` in the same cycle. The entry is removed at the next clock edge.
- R3: On the unified port, an index below NUM_PHYS_INT goes to the integer pool. An index from NUM_PHYS_INT to NUM_PHYS_INT+NUM_PHYS_FP-1 goes to the FP pool. A larger index changes neither pool.
- R4: On the unified port, index ZERO_REG is discarded and is never added to the integer pool.
- R5: When ZERO_FP_EN is 1, the unified port discards index ZERO_REG+NUM_PHYS_INT and does not add it to the FP pool.
- R6: The direct per-pool release ports append the given index unchanged, including zero-register and out-of-range values.
- R7: A request to an empty pool keeps `*_alloc_valid` low, leaves the count unchanged and sets that pool's underflow flag. The flag stays set until reset.
- R8: A push that would raise a pool's count above its capacity (NUM_PHYS_INT or NUM_PHYS_FP) is dropped. It sets that pool's overflow flag, which stays set until reset.
- R9: `*_count` equals the number of held entries, and `*_nonempty` is high exactly when that count is non-zero.
- R10: An allocation and a release to the same pool in one cycle both take effect. The allocation never returns the index being released in that cycle, so an empty pool still underflows. The space freed by the allocation is available to the release.
- R11: When the unified port and the direct port write the same pool in one cycle, both are appended, with the unified-port index placed first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_alloc_req | input | 1 | Request one integer register |
| int_alloc_valid | output | 1 | Integer allocation granted this cycle |
| int_alloc_idx | output | IDX_W | Granted integer register index |
| fp_alloc_req | input | 1 | Request one FP register |
| fp_alloc_valid | output | 1 | FP allocation granted this cycle |
| fp_alloc_idx | output | IDX_W | Granted FP register index |
| rel_valid | input | 1 | Unified release strobe |
| rel_idx | input | IDX_W | Unified release index |
| int_rel_valid | input | 1 | Direct integer release strobe |
| int_rel_idx | input | IDX_W | Direct integer release index |
| fp_rel_valid | input | 1 | Direct FP release strobe |
| fp_rel_idx | input | IDX_W | Direct FP release index |
| int_nonempty | output | 1 | Integer pool holds at least one entry |
| int_count | output | ICW | Integer pool occupancy |
| fp_nonempty | output | 1 | FP pool holds at least one entry |
| fp_count | output | FCW | FP pool occupancy |
| int_underflow | output | 1 | Sticky integer underflow flag |
| fp_underflow | output | 1 | Sticky FP underflow flag |
| int_overflow | output | 1 | Sticky integer overflow flag |
| fp_overflow | output | 1 | Sticky FP overflow flag |

## Verification
Every value of the widened release index goes through the unified port from a fresh reset. This catches a boundary placed one index off, a zero register that leaks back into a pool, and an out-of-range index that wraps into a pool. Same-cycle cases come next. These are an allocation together with a release on the empty pool, where a bypassing design would hand out the register being freed, and on the full pool, where a design that ignores the pop would flag a false overflow. Dual pushes in one cycle are also tested; a wrong write-pointer step would lose or misorder one of them. Draining the pools after each scenario exposes any ordering fault, and flags that clear themselves are caught by checking them on every cycle.

// File: rtl/regfree_pkg.sv
package regfree_pkg;

  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_INT  = 2'd1,
    DEST_FP   = 2'd2
  } dest_e;

  // Decide which pool a unified-port release belongs to.
  function automatic dest_e release_dest(input int idx, input int n_int, input int n_fp,
                                         input int zero_reg, input bit zero_fp_en);
    if (idx < n_int) begin
      return (idx == zero_reg) ? DEST_NONE : DEST_INT;
    end
    if (idx < n_int + n_fp) begin
      if (zero_fp_en && idx == zero_reg + n_int) return DEST_NONE;
      return DEST_FP;
    end
    return DEST_NONE;
  endfunction

  // Circular pointer advance for a depth that need not be a power of two.
  function automatic int ring_step(input int ptr, input int inc, input int depth);
    return (ptr + inc) % depth;
  endfunction

endpackage

// File: rtl/regfree_router.sv
module regfree_router #(
  parameter int IDX_W      = 5,
  parameter int NUM_PHYS_INT = 8,
  parameter int NUM_PHYS_FP  = 8,
  parameter int ZERO_REG   = 0,
  parameter bit ZERO_FP_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_valid,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             to_int,
  output logic             to_fp
);
  import regfree_pkg::*;

  localparam int TOTAL = NUM_PHYS_INT + NUM_PHYS_FP;

  dest_e dest;

  always_comb begin
    dest   = release_dest(int'(rel_idx), NUM_PHYS_INT, NUM_PHYS_FP, ZERO_REG, ZERO_FP_EN);
    to_int = rel_valid && (dest == DEST_INT);
    to_fp  = rel_valid && (dest == DEST_FP);
  end

  // R3: a release lands in at most one pool
  a_r3_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({to_int, to_fp}));

  // R3: indices beyond the physical space are never routed
  a_r3_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && int'(rel_idx) >= TOTAL) |-> (!to_int && !to_fp));

  // R4: the integer zero register never reaches the integer pool
  a_r4_int_zero_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && int'(rel_idx) == ZERO_REG) |-> !to_int);

  // R5: the FP zero register is dropped when enabled
  a_r5_fp_zero_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ZERO_FP_EN && rel_valid && int'(rel_idx) == ZERO_REG + NUM_PHYS_INT) |-> !to_fp);

endmodule

// File: rtl/regfree_pool.sv
module regfree_pool #(
  parameter int DEPTH     = 8,
  parameter int IDX_W     = 5,
  parameter int INIT_BASE = 4,
  parameter int INIT_N    = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_req,
  output logic             pop_valid,
  output logic [IDX_W-1:0] pop_idx,
  input  logic             push0_v,
  input  logic [IDX_W-1:0] push0_idx,
  input  logic             push1_v,
  input  logic [IDX_W-1:0] push1_idx,
  output logic [CW-1:0]    count,
  output logic             nonempty,
  output logic             uf_flag,
  output logic             ov_flag
);
  import regfree_pkg::*;

  logic [IDX_W-1:0] slots [DEPTH];
  logic [PW-1:0]    rd_ptr;
  logic [PW-1:0]    wr_ptr;

  // Named internal events for the assertions
  logic pop_ok;
  logic uf_evt;
  logic acc0;
  logic acc1;
  logic ov_evt;
  int   room_base;

  always_comb begin
    pop_ok    = pop_req && (count != '0);
    uf_evt    = pop_req && (count == '0);
    room_base = int'(count) - int'(pop_ok);
    acc0      = push0_v && (room_base < DEPTH);
    acc1      = push1_v && (room_base + int'(acc0) < DEPTH);
    ov_evt    = (push0_v && !acc0) || (push1_v && !acc1);
    pop_valid = pop_ok;
    pop_idx   = slots[rd_ptr];
    nonempty  = (count != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        slots[i] <= (i < INIT_N) ? IDX_W'(INIT_BASE + i) : '0;
      end
      rd_ptr  <= '0;
      wr_ptr  <= PW'(ring_step(0, INIT_N, DEPTH));
      count   <= CW'(INIT_N);
      uf_flag <= 1'b0;
      ov_flag <= 1'b0;
    end else begin
      if (pop_ok) rd_ptr <= PW'(ring_step(int'(rd_ptr), 1, DEPTH));
      if (acc0) slots[wr_ptr] <= push0_idx;
      if (acc1) slots[PW'(ring_step(int'(wr_ptr), int'(acc0), DEPTH))] <= push1_idx;
      wr_ptr  <= PW'(ring_step(int'(wr_ptr), int'(acc0) + int'(acc1), DEPTH));
      count   <= CW'(int'(count) - int'(pop_ok) + int'(acc0) + int'(acc1));
      if (uf_evt) uf_flag <= 1'b1;
      if (ov_evt) ov_flag <= 1'b1;
    end
  end

  // R9: occupancy never exceeds capacity
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R7: underflow flag is sticky
  a_r7_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    uf_flag |=> uf_flag);

  // R7: a request on an empty pool raises the flag
  a_r7_uf_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !nonempty) |=> uf_flag);

  // R8: overflow flag is sticky
  a_r8_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |=> ov_flag);

  // R8: a full pool with no pop stays exactly full
  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH && !pop_req) |=> int'(count) == DEPTH);

  // R10: a grant on an empty pool is impossible, even with a push in flight
  a_r10_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_valid && count == '0));

endmodule

// File: rtl/regfree_list.sv
module regfree_list #(
  parameter int NUM_LOG_INT  = 4,
  parameter int NUM_PHYS_INT = 8,
  parameter int NUM_LOG_FP   = 4,
  parameter int NUM_PHYS_FP  = 8,
  parameter int ZERO_REG     = 0,
  parameter bit ZERO_FP_EN   = 1'b1,
  localparam int IDX_W = $clog2(NUM_PHYS_INT + NUM_PHYS_FP) + 1,
  localparam int ICW   = $clog2(NUM_PHYS_INT + 1),
  localparam int FCW   = $clog2(NUM_PHYS_FP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_alloc_req,
  output logic             int_alloc_valid,
  output logic [IDX_W-1:0] int_alloc_idx,
  input  logic             fp_alloc_req,
  output logic             fp_alloc_valid,
  output logic [IDX_W-1:0] fp_alloc_idx,
  input  logic             rel_valid,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic             int_rel_valid,
  input  logic [IDX_W-1:0] int_rel_idx,
  input  logic             fp_rel_valid,
  input  logic [IDX_W-1:0] fp_rel_idx,
  output logic             int_nonempty,
  output logic [ICW-1:0]   int_count,
  output logic             fp_nonempty,
  output logic [FCW-1:0]   fp_count,
  output logic             int_underflow,
  output logic             fp_underflow,
  output logic             int_overflow,
  output logic             fp_overflow
);

  logic route_int;
  logic route_fp;

  regfree_router #(
    .IDX_W(IDX_W), .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
    .ZERO_REG(ZERO_REG), .ZERO_FP_EN(ZERO_FP_EN)
  ) u_router (
    .clk(clk), .rst_n(rst_n),
    .rel_valid(rel_valid), .rel_idx(rel_idx),
    .to_int(route_int), .to_fp(route_fp)
  );

  regfree_pool #(
    .DEPTH(NUM_PHYS_INT), .IDX_W(IDX_W),
    .INIT_BASE(NUM_LOG_INT), .INIT_N(NUM_PHYS_INT - NUM_LOG_INT)
  ) u_int_pool (
    .clk(clk), .rst_n(rst_n),
    .pop_req(int_alloc_req), .pop_valid(int_alloc_valid), .pop_idx(int_alloc_idx),
    .push0_v(route_int), .push0_idx(rel_idx),
    .push1_v(int_rel_valid), .push1_idx(int_rel_idx),
    .count(int_count), .nonempty(int_nonempty),
    .uf_flag(int_underflow), .ov_flag(int_overflow)
  );

  regfree_pool #(
    .DEPTH(NUM_PHYS_FP), .IDX_W(IDX_W),
    .INIT_BASE(NUM_PHYS_INT + NUM_LOG_FP), .INIT_N(NUM_PHYS_FP - NUM_LOG_FP)
  ) u_fp_pool (
    .clk(clk), .rst_n(rst_n),
    .pop_req(fp_alloc_req), .pop_valid(fp_alloc_valid), .pop_idx(fp_alloc_idx),
    .push0_v(route_fp), .push0_idx(rel_idx),
    .push1_v(fp_rel_valid), .push1_idx(fp_rel_idx),
    .count(fp_count), .nonempty(fp_nonempty),
    .uf_flag(fp_underflow), .ov_flag(fp_overflow)
  );

endmodule

// File: tb/tb_regfree_list.sv
module tb_regfree_list;

  localparam int NLI = 4, NPI = 8, NLF = 4, NPF = 8;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_alloc_req = 0, fp_alloc_req = 0;
  logic int_alloc_valid, fp_alloc_valid;
  logic [W-1:0] int_alloc_idx, fp_alloc_idx;
  logic rel_valid = 0, int_rel_valid = 0, fp_rel_valid = 0;
  logic [W-1:0] rel_idx = '0, int_rel_idx = '0, fp_rel_idx = '0;
  logic int_nonempty, fp_nonempty;
  logic [3:0] int_count, fp_count;
  logic int_underflow, fp_underflow, int_overflow, fp_overflow;

  always #5 clk = ~clk;

  regfree_list dut (
    .clk(clk), .rst_n(rst_n),
    .int_alloc_req(int_alloc_req), .int_alloc_valid(int_alloc_valid), .int_alloc_idx(int_alloc_idx),
    .fp_alloc_req(fp_alloc_req), .fp_alloc_valid(fp_alloc_valid), .fp_alloc_idx(fp_alloc_idx),
    .rel_valid(rel_valid), .rel_idx(rel_idx),
    .int_rel_valid(int_rel_valid), .int_rel_idx(int_rel_idx),
    .fp_rel_valid(fp_rel_valid), .fp_rel_idx(fp_rel_idx),
    .int_nonempty(int_nonempty), .int_count(int_count),
    .fp_nonempty(fp_nonempty), .fp_count(fp_count),
    .int_underflow(int_underflow), .fp_underflow(fp_underflow),
    .int_overflow(int_overflow), .fp_overflow(fp_overflow)
  );

  int total = 0;
  int bad = 0;
  int iq[$];
  int fq[$];
  bit m_iuf, m_fuf, m_iov, m_fov;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic model_reset();
    iq.delete(); fq.delete();
    for (int i = NLI; i < NPI; i++) iq.push_back(i);
    for (int i = NPI + NLF; i < NPI + NPF; i++) fq.push_back(i);
    m_iuf = 0; m_fuf = 0; m_iov = 0; m_fov = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    int_alloc_req = 0; fp_alloc_req = 0;
    rel_valid = 0; int_rel_valid = 0; fp_rel_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic check_state(input string tag);
    check(int_count == iq.size(), {tag, " R9 int_count"}, int_count, iq.size());
    check(fp_count == fq.size(), {tag, " R9 fp_count"}, fp_count, fq.size());
    check(int_nonempty == (iq.size() != 0), {tag, " R9 int_nonempty"}, int_nonempty, iq.size() != 0);
    check(fp_nonempty == (fq.size() != 0), {tag, " R9 fp_nonempty"}, fp_nonempty, fq.size() != 0);
    check(int_underflow == m_iuf, {tag, " R7 int_underflow"}, int_underflow, m_iuf);
    check(fp_underflow == m_fuf, {tag, " R7 fp_underflow"}, fp_underflow, m_fuf);
    check(int_overflow == m_iov, {tag, " R8 int_overflow"}, int_overflow, m_iov);
    check(fp_overflow == m_fov, {tag, " R8 fp_overflow"}, fp_overflow, m_fov);
  endtask

  // One cycle: drive at the falling edge, check grants mid-cycle, update the model at
  // the rising edge, then compare occupancy and flags after it.
  task automatic step(input string tag, input bit ir, input bit fr,
                      input bit rv, input int ri, input bit iv, input int ii,
                      input bit fv, input int fi);
    int ui_push, uf_push;
    int_alloc_req = ir; fp_alloc_req = fr;
    rel_valid = rv; rel_idx = W'(ri);
    int_rel_valid = iv; int_rel_idx = W'(ii);
    fp_rel_valid = fv; fp_rel_idx = W'(fi);
    #1;
    if (ir) begin
      check(int_alloc_valid == (iq.size() != 0), {tag, " R2 int grant"}, int_alloc_valid, iq.size() != 0);
      if (iq.size() != 0) check(int_alloc_idx == iq[0], {tag, " R2 int idx"}, int_alloc_idx, iq[0]);
    end
    if (fr) begin
      check(fp_alloc_valid == (fq.size() != 0), {tag, " R2 fp grant"}, fp_alloc_valid, fq.size() != 0);
      if (fq.size() != 0) check(fp_alloc_idx == fq[0], {tag, " R2 fp idx"}, fp_alloc_idx, fq[0]);
    end
    @(posedge clk);
    if (ir) begin if (iq.size() == 0) m_iuf = 1; else void'(iq.pop_front()); end
    if (fr) begin if (fq.size() == 0) m_fuf = 1; else void'(fq.pop_front()); end
    ui_push = 0; uf_push = 0;
    if (rv) begin
      if (ri >= 0 && ri < NPI && ri != 0) ui_push = 1;
      else if (ri >= NPI && ri < NPI + NPF && ri != NPI) uf_push = 1;
    end
    if (ui_push) begin if (iq.size() < NPI) iq.push_back(ri); else m_iov = 1; end
    if (iv)      begin if (iq.size() < NPI) iq.push_back(ii); else m_iov = 1; end
    if (uf_push) begin if (fq.size() < NPF) fq.push_back(ri); else m_fov = 1; end
    if (fv)      begin if (fq.size() < NPF) fq.push_back(fi); else m_fov = 1; end
    @(negedge clk);
    int_alloc_req = 0; fp_alloc_req = 0;
    rel_valid = 0; int_rel_valid = 0; fp_rel_valid = 0;
    check_state(tag);
  endtask

  task automatic drain(input string tag);
    while (iq.size() != 0) step(tag, 1, 0, 0, 0, 0, 0, 0, 0);
    while (fq.size() != 0) step(tag, 0, 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset contents and clear flags
    check(int_count == NPI - NLI, "R1 int_count", int_count, NPI - NLI);
    check(fp_count == NPF - NLF, "R1 fp_count", fp_count, NPF - NLF);
    check({int_underflow, fp_underflow, int_overflow, fp_overflow} == 4'b0, "R1 flags",
          {int_underflow, fp_underflow, int_overflow, fp_overflow}, 0);
    // R1/R2: ascending order from reset, then R7 underflow on empty
    for (int k = 0; k < 5; k++) step("R2 int drain", 1, 0, 0, 0, 0, 0, 0, 0);
    check(int_underflow == 1'b1, "R7 int_uf set", int_underflow, 1);
    for (int k = 0; k < 5; k++) step("R2 fp drain", 0, 1, 0, 0, 0, 0, 0, 0);
    check(fp_underflow == 1'b1, "R7 fp_uf set", fp_underflow, 1);
    step("R7 sticky", 0, 0, 0, 0, 0, 0, 0, 0);

    // R10: release into empty pool with concurrent allocation -> underflow, no bypass
    do_reset();
    for (int k = 0; k < 4; k++) step("R10 empty prep", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R10 empty bypass", 1, 0, 1, 3, 0, 0, 0, 0);
    check(int_underflow == 1'b1, "R10 no bypass uf", int_underflow, 1);
    drain("R10 drain");

    // R4/R5/R3 mixed releases, R6 direct unfiltered
    do_reset();
    step("R4 int zero", 0, 0, 1, 0, 0, 0, 0, 0);
    step("R5 fp zero", 0, 0, 1, NPI, 0, 0, 0, 0);
    step("R3 out of range", 0, 0, 1, 20, 0, 0, 0, 0);
    step("R3 int route", 0, 0, 1, 3, 0, 0, 0, 0);
    step("R3 fp route", 0, 0, 1, 9, 0, 0, 0, 0);
    step("R6 direct int zero", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R6 direct fp zero", 0, 0, 0, 0, 0, 0, 1, NPI);
    step("R6 direct oor", 0, 0, 0, 0, 1, 30, 0, 0);
    drain("R6 drain order");

    // R11: unified and direct into the same pool in one cycle
    do_reset();
    step("R11 dual int", 0, 0, 1, 1, 1, 2, 0, 0);
    step("R11 dual fp", 0, 0, 1, 10, 0, 0, 1, 11);
    drain("R11 drain order");

    // R8: fill to capacity then overflow; R10 pop frees room at full
    do_reset();
    for (int k = 0; k < 4; k++) step("R8 fill", 0, 0, 0, 0, 1, k, 1, 8 + k);
    step("R10 full pop+push", 1, 1, 0, 0, 1, 5, 1, 13);
    check(int_overflow == 1'b0, "R10 no false ov", int_overflow, 0);
    step("R8 int overflow", 0, 0, 0, 0, 1, 6, 0, 0);
    step("R8 fp overflow", 0, 0, 1, 14, 0, 0, 0, 0);
    step("R8 sticky", 0, 0, 0, 0, 0, 0, 0, 0);
    drain("R8 drain");

    // R3/R4/R5 sweep of every unified index from a fresh reset
    for (int v = 0; v < (1 << W); v++) begin
      do_reset();
      step("R3 sweep", 0, 0, 1, v, 0, 0, 0, 0);
    end
    finish_run();
  end

endmodule